// File: doc/BRIEF.md
# Region-based memory protection unit

This block checks every access on a 32-bit processor bus against a small set of programmable address windows and answers with allow or fault. Each window has an enable bit, a base and an inclusive limit at 32-byte granularity, a read-only flag and a privileged-only flag. When no window covers an address, an optional background setting can still let privileged accesses through. A global enable turns the whole check off, and every access then passes as though the unit did not exist.

Software sets the unit up through a word-wide register window. A selector register picks the window being edited. Three alias base/limit pairs reach the next three windows after the selected one, so four neighbouring windows can be written without touching the selector again. Two attribute-indirection words are stored for use by other logic. Only privileged full-word accesses reach these registers. Any other register access returns an error and changes nothing.

The number of windows is a parameter. The full instance has eight and the reduced instance has four, and the count must be a power of two.

Top module: `mpu_guard`

## Requirements
- R1: After reset, protection is off, the background setting is off, every window is disabled, and the selector and attribute words read 0.
- R2: Offset 0x90 reads the window count in bits [7:0] with every other bit 0. Writes to it are accepted without error and have no effect.
- R3: At offset 0x94, bit 0 is the global enable and bit 1 is the background enable, and all other bits read 0. While bit 0 is clear, every checked access passes.
- R4: Offset 0x98 holds the selector in its low log2(count) bits. The upper bits read 0 and are dropped on write.
- R5: Offset 0x9C is the selected window's base register: bits [31:5] base, bit 1 read-only, bit 0 privileged-only, bits [4:2] read 0. Offset 0xA0 is its limit register: bits [31:5] limit, bit 0 window enable, bits [4:1] read 0.
- R6: The base/limit pairs at 0xA4/0xA8, 0xAC/0xB0 and 0xB4/0xB8 address window (selector + n) modulo the count, for n = 1, 2, 3.
- R7: Offsets 0xC0 and 0xC4 are two full 32-bit read/write attribute words.
- R8: A register access that is unprivileged, not word-sized (size code 2 = word, 0 = byte, 1 = half-word), not word-aligned, or at an unlisted offset raises cfg_err in the same cycle. It changes no state and reads 0.
- R9: An address hits a window when that window is enabled and base <= address[31:5] <= limit. When several windows hit, the highest-numbered one decides.
- R10: With protection on, a write that hits a read-only window faults, and an unprivileged access that hits a privileged-only window faults.
- R11: With protection on and no window hit, the access faults unless the background enable is set and the access is privileged.
- R12: chk_done rises exactly one cycle after chk_valid, with chk_fault valid in that same cycle. chk_fault is low whenever chk_done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sel | input | 1 | Register access this cycle |
| cfg_wr | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 8 | Byte offset of the register |
| cfg_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| cfg_priv | input | 1 | Register access is privileged |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, same cycle |
| cfg_err | output | 1 | Register access rejected, same cycle |
| chk_valid | input | 1 | Access to check this cycle |
| chk_addr | input | 32 | Address being checked |
| chk_write | input | 1 | Checked access is a write |
| chk_priv | input | 1 | Checked access is privileged |
| chk_done | output | 1 | Check result valid |
| chk_fault | output | 1 | Checked access is refused |

## Verification
A corrupted window table or a wrong priority order shows up on chk_fault in the cycle after the first access that lands in the affected range. An overlapping ro window inside a wider window exposes any error in the priority order at once. Wrong alias arithmetic or a selector that keeps too many bits shows up in the next register read. The bench reads back through a different alias than the one it wrote through, so an index error in either direction changes the data returned. An access that should have been rejected but changed state is caught by reading the target register right after the rejected access.

// File: rtl/mpu_guard.sv
module mpu_guard #(
  parameter int NREG = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_sel,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_addr,
  input  logic [1:0]  cfg_size,
  input  logic        cfg_priv,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        cfg_err,
  input  logic        chk_valid,
  input  logic [31:0] chk_addr,
  input  logic        chk_write,
  input  logic        chk_priv,
  output logic        chk_done,
  output logic        chk_fault
);
  localparam int RW = $clog2(NREG);

  logic [26:0]     base_q  [NREG];
  logic [26:0]     limit_q [NREG];
  logic [NREG-1:0] ro_q, po_q, en_q;
  logic            ctrl_en, ctrl_bg;
  logic [RW-1:0]   rnr_q;
  logic [31:0]     attr0_q, attr1_q;

  wire is_type = cfg_addr == 8'h90;
  wire is_ctrl = cfg_addr == 8'h94;
  wire is_rnr  = cfg_addr == 8'h98;
  wire is_reg  = cfg_addr >= 8'h9C && cfg_addr <= 8'hB8;
  wire is_a0   = cfg_addr == 8'hC0;
  wire is_a1   = cfg_addr == 8'hC4;
  wire mapped  = is_type | is_ctrl | is_rnr | is_reg | is_a0 | is_a1;
  wire word_ok = cfg_size == 2'd2 && cfg_addr[1:0] == 2'b00;

  assign cfg_err = cfg_sel && (!cfg_priv || !word_ok || !mapped);
  wire acc_ok = cfg_sel && !cfg_err;
  wire wr_ok  = acc_ok && cfg_wr;

  logic [7:0]    rel;
  logic [RW-1:0] ridx;
  assign rel  = cfg_addr - 8'h9C;
  assign ridx = rnr_q + RW'(rel[4:3]);
  wire sel_lim = rel[2];

  always_comb begin
    cfg_rdata = '0;
    if (acc_ok && !cfg_wr) begin
      if (is_type)      cfg_rdata = 32'(NREG);
      else if (is_ctrl) cfg_rdata = {30'd0, ctrl_bg, ctrl_en};
      else if (is_rnr)  cfg_rdata = 32'(rnr_q);
      else if (is_reg)  cfg_rdata = sel_lim ? {limit_q[ridx], 4'd0, en_q[ridx]}
                                            : {base_q[ridx], 3'd0, ro_q[ridx], po_q[ridx]};
      else if (is_a0)   cfg_rdata = attr0_q;
      else if (is_a1)   cfg_rdata = attr1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en <= 1'b0;
      ctrl_bg <= 1'b0;
      rnr_q   <= '0;
      attr0_q <= '0;
      attr1_q <= '0;
      ro_q    <= '0;
      po_q    <= '0;
      en_q    <= '0;
      for (int i = 0; i < NREG; i++) begin
        base_q[i]  <= '0;
        limit_q[i] <= '0;
      end
    end else if (wr_ok) begin
      if (is_ctrl) begin
        ctrl_en <= cfg_wdata[0];
        ctrl_bg <= cfg_wdata[1];
      end
      if (is_rnr) rnr_q <= cfg_wdata[RW-1:0];
      if (is_a0) attr0_q <= cfg_wdata;
      if (is_a1) attr1_q <= cfg_wdata;
      if (is_reg) begin
        if (sel_lim) begin
          limit_q[ridx] <= cfg_wdata[31:5];
          en_q[ridx]    <= cfg_wdata[0];
        end else begin
          base_q[ridx] <= cfg_wdata[31:5];
          ro_q[ridx]   <= cfg_wdata[1];
          po_q[ridx]   <= cfg_wdata[0];
        end
      end
    end
  end

  logic hit, hit_ro, hit_po;
  always_comb begin
    hit    = 1'b0;
    hit_ro = 1'b0;
    hit_po = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      if (en_q[i] && chk_addr[31:5] >= base_q[i] && chk_addr[31:5] <= limit_q[i]) begin
        hit    = 1'b1;
        hit_ro = ro_q[i];
        hit_po = po_q[i];
      end
    end
  end

  wire fault_c = ctrl_en && (hit ? ((chk_write && hit_ro) || (!chk_priv && hit_po))
                                 : !(ctrl_bg && chk_priv));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_done  <= 1'b0;
      chk_fault <= 1'b0;
    end else begin
      chk_done  <= chk_valid;
      chk_fault <= chk_valid && fault_c;
    end
  end
endmodule

// File: rtl/mpu_guard_chk.sv
module mpu_guard_chk #(
  parameter int NREG = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_sel,
  input logic        cfg_wr,
  input logic [7:0]  cfg_addr,
  input logic [1:0]  cfg_size,
  input logic        cfg_priv,
  input logic [31:0] cfg_rdata,
  input logic        cfg_err,
  input logic        chk_valid,
  input logic        chk_done,
  input logic        chk_fault,
  input logic        prot_on,
  input logic        bg_on
);
  p_unpriv_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sel && !cfg_priv |-> cfg_err);

  p_size_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sel && cfg_size != 2'd2 |-> cfg_err);

  p_err_keeps_ctrl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> $stable(prot_on) && $stable(bg_on));

  p_err_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> cfg_rdata == 32'd0);

  p_type_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sel && !cfg_wr && !cfg_err && cfg_addr == 8'h90 |-> cfg_rdata == 32'(NREG));

  p_off_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && !prot_on |=> !chk_fault);

  p_done_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> chk_done);

  p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !chk_done);

  p_fault_gated_r12: assert property (@(posedge clk) disable iff (!rst_n)
    chk_fault |-> chk_done);
endmodule

bind mpu_guard mpu_guard_chk #(.NREG(NREG)) u_mpu_guard_chk (
  .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .cfg_size(cfg_size), .cfg_priv(cfg_priv), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
  .chk_valid(chk_valid), .chk_done(chk_done), .chk_fault(chk_fault),
  .prot_on(ctrl_en), .bg_on(ctrl_bg)
);

// File: tb/test_mpu_guard.sv
module test_mpu_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_sel = 1'b0, cfg_wr = 1'b0, cfg_priv = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [1:0]  cfg_size = 2'd2;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_err;
  logic        chk_valid = 1'b0, chk_write = 1'b0, chk_priv = 1'b0;
  logic [31:0] chk_addr = '0;
  logic        chk_done, chk_fault;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mpu_guard #(.NREG(8)) i_mpu_guard (.*);

  // {address, write, privileged, expected fault}
  localparam logic [34:0] VEC [11] = '{
    {32'h1000_0010, 1'b1, 1'b0, 1'b0},
    {32'h1000_8004, 1'b1, 1'b1, 1'b1},
    {32'h1000_8004, 1'b0, 1'b0, 1'b0},
    {32'h1000_8FFC, 1'b1, 1'b1, 1'b1},
    {32'h1000_9000, 1'b1, 1'b0, 1'b0},
    {32'h2000_0000, 1'b0, 1'b0, 1'b1},
    {32'h2000_0FFC, 1'b1, 1'b1, 1'b0},
    {32'h3000_0000, 1'b0, 1'b1, 1'b1},
    {32'h0FFF_FFFC, 1'b0, 1'b1, 1'b1},
    {32'h4000_001C, 1'b0, 1'b0, 1'b0},
    {32'h4000_0020, 1'b0, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_acc(input logic wr, input logic [7:0] a, input logic [31:0] d,
                         input logic pr, input logic [1:0] sz,
                         output logic [31:0] rd, output logic er);
    @(negedge clk);
    cfg_sel = 1'b1; cfg_wr = wr; cfg_addr = a; cfg_wdata = d; cfg_priv = pr; cfg_size = sz;
    #2;
    rd = cfg_rdata; er = cfg_err;
    @(negedge clk);
    cfg_sel = 1'b0; cfg_wr = 1'b0;
  endtask

  task automatic wr32(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] rd; logic er;
    reg_acc(1'b1, a, d, 1'b1, 2'd2, rd, er);
    check("R8 good write no error", 32'(er), 32'd0);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] rd; logic er;
    reg_acc(1'b0, a, '0, 1'b1, 2'd2, rd, er);
    check(req, rd, exp);
  endtask

  task automatic acc_chk(input string req, input logic [31:0] a, input logic w,
                         input logic p, input logic exp);
    @(negedge clk);
    chk_valid = 1'b1; chk_addr = a; chk_write = w; chk_priv = p;
    @(negedge clk);
    chk_valid = 1'b0;
    check({req, " done (R12)"}, 32'(chk_done), 32'd1);
    check(req, 32'(chk_fault), 32'(exp));
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic er;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 done low", 32'(chk_done), 32'd0);
    rd_chk("R1 ctrl", 8'h94, 32'd0);
    rd_chk("R1 selector", 8'h98, 32'd0);
    rd_chk("R1 limit/enable", 8'hA0, 32'd0);
    rd_chk("R1 attr0", 8'hC0, 32'd0);
    acc_chk("R1 off passes", 32'h3000_0000, 1'b1, 1'b0, 1'b0);

    // R2 type
    rd_chk("R2 type", 8'h90, 32'd8);
    wr32(8'h90, 32'h55);
    rd_chk("R2 type write ignored", 8'h90, 32'd8);

    // R5 / R6 programming
    wr32(8'h98, 32'd0);
    wr32(8'h9C, 32'h1000_001C);
    rd_chk("R5 base low bits zero", 8'h9C, 32'h1000_0000);
    wr32(8'hA0, 32'h1000_FFFF);
    rd_chk("R5 limit low bits zero", 8'hA0, 32'h1000_FFE1);
    wr32(8'hA4, 32'h1000_8002);
    wr32(8'hA8, 32'h1000_8FE1);
    wr32(8'hAC, 32'h2000_0001);
    wr32(8'hB0, 32'h2000_0FE1);
    wr32(8'hB4, 32'h4000_0000);
    wr32(8'hB8, 32'h4000_0001);
    rd_chk("R6 alias1 via base", 8'hA4, 32'h1000_8002);
    wr32(8'h98, 32'd3);
    rd_chk("R6 alias0 reaches region3", 8'h9C, 32'h4000_0000);
    wr32(8'h98, 32'hFFFF_FFFE);
    rd_chk("R4 selector width", 8'h98, 32'd6);
    rd_chk("R6 alias3 wraps to region1", 8'hB4, 32'h1000_8002);
    rd_chk("R6 alias2 wraps to region0 limit", 8'hB0, 32'h1000_FFE1);

    // R3 control
    wr32(8'h94, 32'hFFFF_FFFD);
    rd_chk("R3 ctrl upper bits zero", 8'h94, 32'd1);

    // R9 R10 R11 vector table
    foreach (VEC[i]) begin
      acc_chk($sformatf("R9/R10/R11 vector %0d", i), VEC[i][34:3], VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R12 idle after check
    @(negedge clk);
    check("R12 done idle", 32'(chk_done), 32'd0);
    check("R12 fault idle", 32'(chk_fault), 32'd0);

    // R8 rejected accesses
    reg_acc(1'b1, 8'h94, 32'd0, 1'b0, 2'd2, rd, er);
    check("R8 unpriv err", 32'(er), 32'd1);
    rd_chk("R8 ctrl unchanged", 8'h94, 32'd1);
    reg_acc(1'b0, 8'h94, 32'd0, 1'b0, 2'd2, rd, er);
    check("R8 unpriv read zero", rd, 32'd0);
    reg_acc(1'b1, 8'hC0, 32'h1234_5678, 1'b1, 2'd0, rd, er);
    check("R8 byte err", 32'(er), 32'd1);
    reg_acc(1'b1, 8'hC0, 32'h1234_5678, 1'b1, 2'd1, rd, er);
    check("R8 half err", 32'(er), 32'd1);
    rd_chk("R8 attr0 unchanged", 8'hC0, 32'd0);
    reg_acc(1'b0, 8'hBC, 32'd0, 1'b1, 2'd2, rd, er);
    check("R8 unmapped err", 32'(er), 32'd1);
    check("R8 unmapped reads zero", rd, 32'd0);
    reg_acc(1'b1, 8'hC1, 32'hFFFF_FFFF, 1'b1, 2'd2, rd, er);
    check("R8 misaligned err", 32'(er), 32'd1);

    // R7 attributes
    wr32(8'hC4, 32'hDEAD_BEEF);
    wr32(8'hC0, 32'h0BAD_F00D);
    rd_chk("R7 attr1", 8'hC4, 32'hDEAD_BEEF);
    rd_chk("R7 attr0", 8'hC0, 32'h0BAD_F00D);

    // R11 background
    wr32(8'h94, 32'd3);
    acc_chk("R11 bg privileged miss passes", 32'h3000_0000, 1'b1, 1'b1, 1'b0);
    acc_chk("R11 bg unprivileged miss faults", 32'h3000_0000, 1'b0, 1'b0, 1'b1);
    acc_chk("R10 region rules still apply with bg", 32'h1000_8004, 1'b1, 1'b1, 1'b1);

    // R9 disabled window ignored
    wr32(8'h98, 32'd1);
    wr32(8'hA0, 32'h1000_8FE0);
    acc_chk("R9 disabled window skipped", 32'h1000_8004, 1'b1, 1'b0, 1'b0);

    // R3 global disable
    wr32(8'h94, 32'd0);
    acc_chk("R3 off passes miss", 32'h3000_0000, 1'b0, 1'b0, 1'b0);
    acc_chk("R3 off passes privileged-only", 32'h2000_0000, 1'b1, 1'b0, 1'b0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule